// File: doc/BRIEF.md
# Clock-Generator Mode Input Remapper

This block sits between a tester's pattern inputs and a bank of channel timing engines. It has two modes. In normal tester mode one period-start strobe and one delay offset are shared by all channels. Each channel's pattern data byte is its waveform memory address, and each mask bit suppresses fail reporting for the matching edge on every channel.

In programmable-clock mode the same pins take new roles. Mask bit N becomes the period start of channel N, and channel N's pattern data byte becomes that channel's delay offset. Every waveform address is held at zero, fail masking is switched off and the data-valid input is ignored. Each channel can then run as an independent clock generator.

Clock mode is selected only while both the shared period-start input and the mode-enable input are high. The mode is evaluated on every master-clock edge. Every output is registered, so a mode change appears at the outputs on the next edge together with the remapped values.

Top module: `cgm_remap`

## Requirements
- R1: While reset is asserted, every output is 0: mode flag, period starts, addresses, address-valid, delay offsets and fail masks.
- R2: `clk_mode_o` is 1 exactly when, at the previous rising edge, `period_start_i` and `clkgen_en_i` were both 1. With either input low, the block is in normal mode.
- R3: In normal mode, every bit of `chan_start_o` equals the sampled `period_start_i`.
- R4: In normal mode, `wave_addr_o[8n+7:8n]` equals `pat_data_i[8n+7:8n]` for each channel n, and `wave_valid_o` equals the sampled `data_valid_i`.
- R5: In normal mode, every channel's field of `delay_o` (bits 8n+7:8n) equals `shared_delay_i`.
- R6: In normal mode, `fail_mask_o[n]` equals `mask_i[n]` (bit n masks edge n on all channels).
- R7: In clock mode, `chan_start_o[n]` equals the sampled `mask_i[n]`.
- R8: In clock mode, all of `wave_addr_o` is 0 and `wave_valid_o` is 1 whatever `data_valid_i` holds.
- R9: In clock mode, `delay_o[8n+7:8n]` equals `pat_data_i[8n+7:8n]`, and `shared_delay_i` has no effect.
- R10: In clock mode, `fail_mask_o` is 0 whatever `mask_i` holds.
- R11: All outputs change only at a rising clock edge. An input change between edges is not visible at the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| period_start_i | input | 1 | Shared period-start strobe |
| clkgen_en_i | input | 1 | Clock-generator mode enable |
| data_valid_i | input | 1 | Pattern data valid (normal mode only) |
| mask_i | input | NUM_CH | Edge fail masks, or per-channel period starts in clock mode |
| pat_data_i | input | NUM_CH*DATA_W | Per-channel pattern data, 8 bits each |
| shared_delay_i | input | DATA_W | Delay offset shared by all channels in normal mode |
| clk_mode_o | output | 1 | Registered mode flag, 1 = clock mode |
| chan_start_o | output | NUM_CH | Per-channel period start |
| wave_addr_o | output | NUM_CH*DATA_W | Per-channel waveform memory address |
| wave_valid_o | output | 1 | Waveform address valid |
| delay_o | output | NUM_CH*DATA_W | Per-channel delay offset |
| fail_mask_o | output | NUM_CH | Per-edge fail mask |

## Verification
The bench builds the block with its default of four channels and 8-bit data. Every lane therefore has its own distinct byte, and a swapped or mis-indexed lane slice shows up as a wrong value. The bench sets the mode enable with the strobe low, and the strobe with the enable low, to check that both are needed. It toggles data-valid, the mask bits and the shared delay while in clock mode to show that they have no effect there. It also changes inputs between edges to show that the outputs are registered.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CLKGEN = 1'b1
    } cgm_mode_e;
endpackage

// File: rtl/cgm_mode_dec.sv
module cgm_mode_dec
    import cgm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      period_start_i,
    input  logic      clkgen_en_i,
    input  logic      data_valid_i,
    output cgm_mode_e mode_c_o,
    output logic      clk_mode_o,
    output logic      wave_valid_o
);
    typedef struct packed {
        cgm_mode_e mode;
        logic      valid;
    } dec_state_t;

    dec_state_t st_d, st_q;
    cgm_mode_e  mode_c;

    always_comb begin
        mode_c = (period_start_i && clkgen_en_i) ? MODE_CLKGEN : MODE_NORMAL;
        st_d.mode  = mode_c;
        st_d.valid = (mode_c == MODE_CLKGEN) ? 1'b1 : data_valid_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_c_o     = mode_c;
    assign clk_mode_o   = (st_q.mode == MODE_CLKGEN);
    assign wave_valid_o = st_q.valid;

    // R2
    mode_follows_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clk_mode_o == ($past(period_start_i) && $past(clkgen_en_i))));

    // R8
    valid_forced_in_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode_o |-> wave_valid_o);
endmodule

// File: rtl/cgm_lane.sv
module cgm_lane
    import cgm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cgm_mode_e         mode_c_i,
    input  logic              period_start_i,
    input  logic              mask_bit_i,
    input  logic [DATA_W-1:0] pat_data_i,
    input  logic [DATA_W-1:0] shared_delay_i,
    output logic              start_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] delay_o
);
    localparam logic [DATA_W-1:0] FIXED_ADDR = '0;

    typedef struct packed {
        logic              start;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] delay;
    } lane_state_t;

    lane_state_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        unique case (mode_c_i)
            MODE_CLKGEN: begin
                ln_d.start = mask_bit_i;
                ln_d.addr  = FIXED_ADDR;
                ln_d.delay = pat_data_i;
            end
            default: begin
                ln_d.start = period_start_i;
                ln_d.addr  = pat_data_i;
                ln_d.delay = shared_delay_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign start_o = ln_q.start;
    assign addr_o  = ln_q.addr;
    assign delay_o = ln_q.delay;

    // R7
    clk_start_from_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_CLKGEN) |-> (start_o == $past(mask_bit_i)));

    // R8
    clk_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_CLKGEN) |-> (addr_o == '0));

    // R9
    clk_delay_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_CLKGEN) |-> (delay_o == $past(pat_data_i)));

    // R5
    norm_delay_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_NORMAL) |-> (delay_o == $past(shared_delay_i)));
endmodule

// File: rtl/cgm_fail_mask.sv
module cgm_fail_mask
    import cgm_pkg::*;
#(
    parameter int NUM_EDGE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cgm_mode_e           mode_c_i,
    input  logic [NUM_EDGE-1:0] mask_i,
    output logic [NUM_EDGE-1:0] fail_mask_o
);
    logic [NUM_EDGE-1:0] fm_d, fm_q;

    always_comb begin
        fm_d = (mode_c_i == MODE_CLKGEN) ? '0 : mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fm_q <= '0;
        end else begin
            fm_q <= fm_d;
        end
    end

    assign fail_mask_o = fm_q;

    // R10
    clk_no_masking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_CLKGEN) |-> (fail_mask_o == '0));

    // R6
    norm_mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_c_i) == MODE_NORMAL) |-> (fail_mask_o == $past(mask_i)));
endmodule

// File: rtl/cgm_remap.sv
module cgm_remap
    import cgm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     period_start_i,
    input  logic                     clkgen_en_i,
    input  logic                     data_valid_i,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [NUM_CH*DATA_W-1:0] pat_data_i,
    input  logic [DATA_W-1:0]        shared_delay_i,
    output logic                     clk_mode_o,
    output logic [NUM_CH-1:0]        chan_start_o,
    output logic [NUM_CH*DATA_W-1:0] wave_addr_o,
    output logic                     wave_valid_o,
    output logic [NUM_CH*DATA_W-1:0] delay_o,
    output logic [NUM_CH-1:0]        fail_mask_o
);
    cgm_mode_e mode_c;

    cgm_mode_dec u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_start_i (period_start_i),
        .clkgen_en_i    (clkgen_en_i),
        .data_valid_i   (data_valid_i),
        .mode_c_o       (mode_c),
        .clk_mode_o     (clk_mode_o),
        .wave_valid_o   (wave_valid_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        cgm_lane #(.DATA_W(DATA_W)) u_lane (
            .clk            (clk),
            .rst_n          (rst_n),
            .mode_c_i       (mode_c),
            .period_start_i (period_start_i),
            .mask_bit_i     (mask_i[ch]),
            .pat_data_i     (pat_data_i[ch*DATA_W +: DATA_W]),
            .shared_delay_i (shared_delay_i),
            .start_o        (chan_start_o[ch]),
            .addr_o         (wave_addr_o[ch*DATA_W +: DATA_W]),
            .delay_o        (delay_o[ch*DATA_W +: DATA_W])
        );
    end

    cgm_fail_mask #(.NUM_EDGE(NUM_CH)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_c_i    (mode_c),
        .mask_i      (mask_i),
        .fail_mask_o (fail_mask_o)
    );

    // R3
    norm_start_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !clk_mode_o) |-> (chan_start_o == {NUM_CH{$past(period_start_i)}}));

    // R4
    norm_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !clk_mode_o) |-> (wave_addr_o == $past(pat_data_i)));
endmodule

// File: tb/cgm_remap_bench.sv
module cgm_remap_bench;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 8;
    localparam int PW     = NUM_CH*DATA_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          per_s = 1'b0, cg_en = 1'b0, dv = 1'b0;
    logic [NUM_CH-1:0] msk = '0;
    logic [PW-1:0] pdat = '0;
    logic [DATA_W-1:0] sdly = '0;
    logic          mode_o, valid_o;
    logic [NUM_CH-1:0] start_o, fmask_o;
    logic [PW-1:0] addr_o, dly_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cgm_remap #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cgm_remap (
        .clk(clk), .rst_n(rst_n),
        .period_start_i(per_s), .clkgen_en_i(cg_en), .data_valid_i(dv),
        .mask_i(msk), .pat_data_i(pdat), .shared_delay_i(sdly),
        .clk_mode_o(mode_o), .chan_start_o(start_o), .wave_addr_o(addr_o),
        .wave_valid_o(valid_o), .delay_o(dly_o), .fail_mask_o(fmask_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
    task automatic apply(input logic p, input logic e, input logic v,
                         input logic [NUM_CH-1:0] m, input logic [PW-1:0] d,
                         input logic [DATA_W-1:0] s);
        @(negedge clk);
        per_s = p; cg_en = e; dv = v; msk = m; pdat = d; sdly = s;
        @(negedge clk);
    endtask

    // Expected outputs derived from the requirements for the inputs now applied.
    task automatic check_all(input string tag);
        logic cm;
        cm = per_s && cg_en;
        chk({tag, " R2 mode"}, 64'(mode_o), 64'(cm));
        if (!cm) begin
            chk({tag, " R3 start"}, 64'(start_o), 64'({NUM_CH{per_s}}));
            chk({tag, " R4 addr"},  64'(addr_o),  64'(pdat));
            chk({tag, " R4 valid"}, 64'(valid_o), 64'(dv));
            chk({tag, " R5 delay"}, 64'(dly_o),   64'({NUM_CH{sdly}}));
            chk({tag, " R6 mask"},  64'(fmask_o), 64'(msk));
        end else begin
            chk({tag, " R7 start"}, 64'(start_o), 64'(msk));
            chk({tag, " R8 addr"},  64'(addr_o),  64'(0));
            chk({tag, " R8 valid"}, 64'(valid_o), 64'(1));
            chk({tag, " R9 delay"}, 64'(dly_o),   64'(pdat));
            chk({tag, " R10 mask"}, 64'(fmask_o), 64'(0));
        end
    endtask

    task automatic t_reset;
        per_s = 1'b1; cg_en = 1'b1; dv = 1'b1; msk = '1; pdat = '1; sdly = '1;
        repeat (3) @(negedge clk);
        chk("R1 reset mode",  64'(mode_o),  64'(0));
        chk("R1 reset start", 64'(start_o), 64'(0));
        chk("R1 reset addr",  64'(addr_o),  64'(0));
        chk("R1 reset valid", 64'(valid_o), 64'(0));
        chk("R1 reset delay", 64'(dly_o),   64'(0));
        chk("R1 reset mask",  64'(fmask_o), 64'(0));
        per_s = 0; cg_en = 0; dv = 0; msk = '0; pdat = '0; sdly = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_normal;
        apply(1, 0, 1, 4'b1010, 32'h44332211, 8'h5A); check_all("normal a");
        apply(0, 0, 0, 4'b0101, 32'hDEADBEEF, 8'hC3); check_all("normal b");
        apply(0, 1, 1, 4'b1111, 32'h0F1E2D3C, 8'h77); check_all("enable only R2");
        apply(1, 0, 0, 4'b0011, 32'h80706050, 8'h01); check_all("strobe only R2");
    endtask

    task automatic t_clock;
        apply(1, 1, 0, 4'b1001, 32'hA1B2C3D4, 8'h99); check_all("clock a");
        apply(1, 1, 1, 4'b0110, 32'h01020304, 8'h00); check_all("clock dv ignored R8");
        apply(1, 1, 0, 4'b1111, 32'hFFEE0011, 8'hFF); check_all("clock mask ignored R10");
        apply(1, 1, 1, 4'b0000, 32'h12345678, 8'h3C); check_all("clock shared delay R9");
        apply(1, 0, 1, 4'b1100, 32'h55AA55AA, 8'h42); check_all("back to normal R2");
    endtask

    task automatic t_registered;
        logic [PW-1:0] held_a, held_d;
        logic [NUM_CH-1:0] held_s;
        apply(0, 0, 1, 4'b0001, 32'h10203040, 8'h11);
        held_a = addr_o; held_d = dly_o; held_s = start_o;
        per_s = 1; cg_en = 1; msk = 4'b1110; pdat = 32'h99887766; sdly = 8'hEE;
        #1;
        chk("R11 addr held",  64'(addr_o),  64'(held_a));
        chk("R11 delay held", 64'(dly_o),   64'(held_d));
        chk("R11 start held", 64'(start_o), 64'(held_s));
        chk("R11 mode held",  64'(mode_o),  64'(0));
        @(negedge clk);
        check_all("R11 after edge");
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_clock();
        t_registered();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule